// File: doc/BRIEF.md
# Paged Memory Bank Address Decoder

This block sits between an 8-bit host processor with a 16-bit address bus and the external program and secondary memories. It stretches the host's 64 KB map into two physical regions of up to sixteen 16 KB pages each, which is 256 KB per region. The CPU writes a bank register at a fixed address. The register picks the page, and the region, that appear in the one banked CPU window, 8000–BFFF. Every other external CPU address is a root access. A root access lands in the top four pages of the program region, physical 30000–3FFFF. The same memory can therefore be reached two ways: through its root address, or through the window with the matching bank value. This is useful when a flash device is programmed page by page.

The decoder produces an 18-bit physical address and two active-low chip selects, one for the program region and one for the secondary region. Both come combinationally from the CPU address and a valid strobe. The host's internal register space, 0000–00FF, which also holds the bank register, drives neither chip select. Pages in the secondary region can be distinct memory, or the board can wire them as shadows of program pages.

Top module: `bank_decoder`

## Requirements
- R1: On reset the bank register holds 8'h0F, so an access to 8000 reaches physical 3C000 of the program region, the same location as root address C000.
- R2: A cycle with cpu_valid=1, cpu_we=1 and cpu_addr=0030 loads cpu_wdata into the bank register at that clock edge. A cycle missing any of these three conditions leaves the register unchanged.
- R3: For every CPU address outside 8000–BFFF, phys_addr is {2'b11, cpu_addr}.
- R4: For a CPU address inside 8000–BFFF, phys_addr is {bank[3:0], cpu_addr[13:0]}, where bank[3:0] is the page number 0–15.
- R5: Bank bit 4 selects the region of the window: 0 drives cs_prog_n low, 1 drives cs_sec_n low. Root accesses always use the program region.
- R6: A valid access to 0000–00FF drives both chip selects high. This range includes the bank register address.
- R7: With cpu_valid=0, both chip selects are high.
- R8: At most one chip select is low at any time.
- R9: Bank bits 7:5 have no effect on the physical address or on the chip selects.
- R10: phys_addr and the chip selects follow cpu_addr in the same cycle, with no register in the path. A bank write takes effect from the cycle after its clock edge.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Host address |
| cpu_wdata | input | 8 | Host write data |
| cpu_we | input | 1 | Host write strobe |
| cpu_valid | input | 1 | Host access valid |
| phys_addr | output | 18 | Physical address within the selected region |
| cs_prog_n | output | 1 | Program region chip select, active low |
| cs_sec_n | output | 1 | Secondary region chip select, active low |

## Verification
The only state in this block is the bank register. A wrong value there shows up at the ports during the first window access after the write that produced it. That access shows a wrong upper phys_addr nibble, or the wrong chip select going low. Root and internal accesses do not depend on the bank register, so each bank value is checked through a window access immediately after the write. Ignored writes and the dead upper bits are checked the same way: a window access follows the stimulus that should have had no effect.

// File: rtl/bank_decoder_pkg.sv
package bank_decoder_pkg;

  typedef enum logic {
    REGION_PROG = 1'b0,
    REGION_SEC  = 1'b1
  } region_e;

endpackage

// File: rtl/bank_reg.sv
module bank_reg #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] REG_ADDR = 16'h0030,
  parameter logic [7:0]  RST_VAL  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bank_q
);

  logic hit;

  always_comb begin
    hit = valid && we && (addr == REG_ADDR[ADDR_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= RST_VAL[DATA_W-1:0];
    end else if (hit) begin
      bank_q <= wdata;
    end
  end

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_decoder_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          PAGE_W   = 14,
  parameter int          SEL_W    = 4,
  parameter logic [1:0]  WIN_IDX  = 2'b10,
  parameter logic [15:0] INT_BASE = 16'h0000,
  parameter logic [15:0] INT_MASK = 16'h00FF,
  localparam int PHYS_W = SEL_W + PAGE_W,
  localparam int IDX_W  = ADDR_W - PAGE_W,
  localparam int TOP_W  = PHYS_W - ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  page,
  input  logic              region_bit,
  output logic [PHYS_W-1:0] phys,
  output region_e           region,
  output logic              internal
);

  logic              in_window;
  logic [PHYS_W-1:0] root_phys;

  always_comb begin
    in_window = (addr[ADDR_W-1:PAGE_W] == WIN_IDX[IDX_W-1:0]);
    internal  = ((addr & ~INT_MASK[ADDR_W-1:0]) == INT_BASE[ADDR_W-1:0]);
  end

  generate
    if (TOP_W > 0) begin : g_root_wide
      always_comb root_phys = {{TOP_W{1'b1}}, addr};
    end else begin : g_root_narrow
      always_comb root_phys = addr[PHYS_W-1:0];
    end
  endgenerate

  always_comb begin
    if (in_window) begin
      phys   = {page, addr[PAGE_W-1:0]};
      region = region_bit ? REGION_SEC : REGION_PROG;
    end else begin
      phys   = root_phys;
      region = REGION_PROG;
    end
  end

endmodule

// File: rtl/bank_csgen.sv
module bank_csgen
  import bank_decoder_pkg::*;
(
  input  logic    valid,
  input  logic    internal,
  input  region_e region,
  output logic    cs_prog_n,
  output logic    cs_sec_n
);

  logic ext;

  always_comb begin
    ext       = valid && !internal;
    cs_prog_n = !(ext && (region == REGION_PROG));
    cs_sec_n  = !(ext && (region == REGION_SEC));
  end

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_decoder_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          PAGE_W     = 14,
  parameter int          SEL_W      = 4,
  parameter int          REGION_BIT = 4,
  parameter logic [15:0] REG_ADDR   = 16'h0030,
  parameter logic [7:0]  RST_BANK   = 8'h0F,
  parameter logic [1:0]  WIN_IDX    = 2'b10,
  parameter logic [15:0] INT_BASE   = 16'h0000,
  parameter logic [15:0] INT_MASK   = 16'h00FF,
  localparam int PHYS_W = SEL_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_valid,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              cs_prog_n,
  output logic              cs_sec_n
);

  logic [DATA_W-1:0] bank_q;
  region_e           region;
  logic              internal;

  bank_reg #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR),
    .RST_VAL (RST_BANK)
  ) u_reg (
    .clk   (clk),
    .rst   (rst),
    .valid (cpu_valid),
    .we    (cpu_we),
    .addr  (cpu_addr),
    .wdata (cpu_wdata),
    .bank_q(bank_q)
  );

  bank_xlate #(
    .ADDR_W  (ADDR_W),
    .PAGE_W  (PAGE_W),
    .SEL_W   (SEL_W),
    .WIN_IDX (WIN_IDX),
    .INT_BASE(INT_BASE),
    .INT_MASK(INT_MASK)
  ) u_xlate (
    .addr      (cpu_addr),
    .page      (bank_q[SEL_W-1:0]),
    .region_bit(bank_q[REGION_BIT]),
    .phys      (phys_addr),
    .region    (region),
    .internal  (internal)
  );

  bank_csgen u_cs (
    .valid    (cpu_valid),
    .internal (internal),
    .region   (region),
    .cs_prog_n(cs_prog_n),
    .cs_sec_n (cs_sec_n)
  );

endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk #(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          PAGE_W     = 14,
  parameter int          SEL_W      = 4,
  parameter int          REGION_BIT = 4,
  parameter logic [15:0] REG_ADDR   = 16'h0030,
  parameter logic [7:0]  RST_BANK   = 8'h0F,
  parameter logic [1:0]  WIN_IDX    = 2'b10,
  parameter logic [15:0] INT_BASE   = 16'h0000,
  parameter logic [15:0] INT_MASK   = 16'h00FF,
  localparam int PHYS_W = SEL_W + PAGE_W,
  localparam int TOP_W  = PHYS_W - ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_we,
  input logic              cpu_valid,
  input logic [PHYS_W-1:0] phys_addr,
  input logic              cs_prog_n,
  input logic              cs_sec_n,
  input logic [DATA_W-1:0] bank_q
);

  logic              rst_q = 1'b0;
  logic              wr_q = 1'b0;
  logic              live_q = 1'b0;
  logic [DATA_W-1:0] wdata_q = '0;
  logic [DATA_W-1:0] bank_prev = '0;
  logic              win;
  logic              intl;

  always_comb begin
    win  = (cpu_addr[ADDR_W-1:PAGE_W] == WIN_IDX[ADDR_W-PAGE_W-1:0]);
    intl = ((cpu_addr & ~INT_MASK[ADDR_W-1:0]) == INT_BASE[ADDR_W-1:0]);
  end

  always_ff @(posedge clk) begin
    rst_q     <= rst;
    live_q    <= !rst;
    wr_q      <= !rst && cpu_valid && cpu_we && (cpu_addr == REG_ADDR[ADDR_W-1:0]);
    wdata_q   <= cpu_wdata;
    bank_prev <= bank_q;
  end

  AST_RESET_BANK: assert property (@(posedge clk)
    rst_q |-> bank_q == RST_BANK[DATA_W-1:0]); // R1

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_q |-> bank_q == wdata_q); // R2

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (live_q && !wr_q && !rst_q) |-> bank_q == bank_prev); // R2

  AST_ROOT_PHYS: assert property (@(posedge clk) disable iff (rst)
    !win |-> phys_addr == {{TOP_W{1'b1}}, cpu_addr}); // R3

  AST_WIN_PHYS: assert property (@(posedge clk) disable iff (rst)
    win |-> phys_addr == {bank_q[SEL_W-1:0], cpu_addr[PAGE_W-1:0]}); // R4

  AST_ROOT_NO_SEC: assert property (@(posedge clk) disable iff (rst)
    !win |-> cs_sec_n); // R5

  AST_WIN_REGION: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && win) |-> (bank_q[REGION_BIT] ? !cs_sec_n : !cs_prog_n)); // R5

  AST_INTERNAL: assert property (@(posedge clk) disable iff (rst)
    intl |-> (cs_prog_n && cs_sec_n)); // R6

  AST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |-> (cs_prog_n && cs_sec_n)); // R7

  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $countones({!cs_prog_n, !cs_sec_n}) <= 1); // R8

endmodule

bind bank_decoder bank_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PAGE_W    (PAGE_W),
  .SEL_W     (SEL_W),
  .REGION_BIT(REGION_BIT),
  .REG_ADDR  (REG_ADDR),
  .RST_BANK  (RST_BANK),
  .WIN_IDX   (WIN_IDX),
  .INT_BASE  (INT_BASE),
  .INT_MASK  (INT_MASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_addr (cpu_addr),
  .cpu_wdata(cpu_wdata),
  .cpu_we   (cpu_we),
  .cpu_valid(cpu_valid),
  .phys_addr(phys_addr),
  .cs_prog_n(cs_prog_n),
  .cs_sec_n (cs_sec_n),
  .bank_q   (bank_q)
);

// File: tb/bank_decoder_bench.sv
module bank_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_valid = 1'b0;
  logic [17:0] phys_addr;
  logic        cs_prog_n;
  logic        cs_sec_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_decoder u_bank_decoder (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_we   (cpu_we),
    .cpu_valid(cpu_valid),
    .phys_addr(phys_addr),
    .cs_prog_n(cs_prog_n),
    .cs_sec_n (cs_sec_n)
  );

  // {cpu_addr, expected phys, expected cs_prog_n, expected cs_sec_n}, bank = 0F
  localparam logic [35:0] VEC [10] = '{
    {16'h0100, 18'h30100, 1'b0, 1'b1},  // R3
    {16'h3FFF, 18'h33FFF, 1'b0, 1'b1},  // R3
    {16'h4000, 18'h34000, 1'b0, 1'b1},  // R3
    {16'h8000, 18'h3C000, 1'b0, 1'b1},  // R1 R4
    {16'hBFFF, 18'h3FFFF, 1'b0, 1'b1},  // R4
    {16'hC000, 18'h3C000, 1'b0, 1'b1},  // R1 R3
    {16'hFFFF, 18'h3FFFF, 1'b0, 1'b1},  // R3
    {16'h0030, 18'h30030, 1'b1, 1'b1},  // R6
    {16'h00FF, 18'h300FF, 1'b1, 1'b1},  // R6
    {16'h0000, 18'h30000, 1'b1, 1'b1}   // R6
  };

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic [15:0] a,
                       input logic [17:0] ep, input logic ecp, input logic ecs);
    @(negedge clk);
    cpu_addr  = a;
    cpu_valid = 1'b1;
    cpu_we    = 1'b0;
    #1;
    check(req, {phys_addr, cs_prog_n, cs_sec_n}, {ep, ecp, ecs});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic v, input logic w);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_valid = v;
    cpu_we    = w;
    @(negedge clk);
    cpu_we    = 1'b0;
    cpu_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state via a window access
    probe("R1", 16'h8123, 18'h3C123, 1'b0, 1'b1);
    foreach (VEC[i]) begin
      probe("R3/R4/R6 vector", VEC[i][35:20], VEC[i][19:2], VEC[i][1], VEC[i][0]);
    end
    // R7 idle
    @(negedge clk);
    cpu_addr = 16'hC000; cpu_valid = 1'b0; #1;
    check("R7", {phys_addr, cs_prog_n, cs_sec_n}, {18'h3C000, 1'b1, 1'b1});
    // R2 load page 5, R10 same-cycle after
    wr(16'h0030, 8'h05, 1'b1, 1'b1);
    probe("R2 R4 R10", 16'h8123, 18'h14123, 1'b0, 1'b1);
    probe("R4 boundary", 16'hBFFF, 18'h17FFF, 1'b0, 1'b1);
    // R5 secondary region
    wr(16'h0030, 8'h13, 1'b1, 1'b1);
    probe("R5 window", 16'h8000, 18'h0C000, 1'b1, 1'b0);
    probe("R5 root", 16'hC000, 18'h3C000, 1'b0, 1'b1);
    probe("R5 root low", 16'h4001, 18'h34001, 1'b0, 1'b1);
    probe("R6 reg addr", 16'h0030, 18'h30030, 1'b1, 1'b1);
    // R2 ignored writes
    wr(16'h0030, 8'h02, 1'b1, 1'b0);
    probe("R2 no we", 16'h8000, 18'h0C000, 1'b1, 1'b0);
    wr(16'h0030, 8'h02, 1'b0, 1'b1);
    probe("R2 no valid", 16'h8000, 18'h0C000, 1'b1, 1'b0);
    wr(16'h0031, 8'h02, 1'b1, 1'b1);
    probe("R2 other addr", 16'h8000, 18'h0C000, 1'b1, 1'b0);
    // R9 upper bits ignored
    wr(16'h0030, 8'hE5, 1'b1, 1'b1);
    probe("R9", 16'h8123, 18'h14123, 1'b0, 1'b1);
    wr(16'h0030, 8'hF3, 1'b1, 1'b1);
    probe("R9 sec", 16'h8010, 18'h0C010, 1'b1, 1'b0);
    // R1 reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    probe("R1 rereset", 16'h8000, 18'h3C000, 1'b0, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule